// File: doc/BRIEF.md
# Matrix Keyboard and Switch Scanner

This block drives four scan strobes across a key matrix and reads eight key return lines on each strobe, covering 32 key positions. It reads eight further switch return lines on the same strobes, which gives the static level of 16 switches. Each key return is debounced over whole scan cycles. Only a debounced change from released to pressed yields an event. The event becomes a 5-bit code made of the strobe number and the return number. That code is held, and the key-pending output stays high, until the host reads it.

The host reads over a serial command input. It shifts in an 8-bit word, most significant bit first, while a framing strobe is high. The read word 8'hA5 makes the block send the held code back, most significant bit first, over five clocks on a serial output with a valid flag. The read also clears the pending and alarm flags. A press that arrives while a code is still unread is thrown away and raises the alarm output. Because a held key never blocks a new event, two-key rollover comes for free.

Top module: `keyscan_matrix`

## Requirements
- R1: After reset the strobe output is all zero until the first clock edge. From then on exactly one strobe bit is high, stepping 0,1,2,3,0,... Each strobe stays high for DWELL clocks (default 4).
- R2: A key on strobe s (0..3) and return line r (0..7) reports the code s*8+r, so bits [4:3] are s and bits [2:0] are r.
- R3: An event is raised only when a key's debounced state goes from released to pressed. A held key and a released key raise none. A key that is released and pressed again raises a new event.
- R4: A key must read the same level at two consecutive samples, one full scan apart, before its debounced state changes. A press seen at only one sample is ignored.
- R5: While one key is held, a press of a second key is captured and reported. The first key does not have to be released.
- R6: On mi_sync, mi is shifted in one bit per clock, MSB first. When the 8th bit of a word completes 8'hA5 and a code is pending, code_valid goes high for the next 5 clocks, starting the cycle after that edge. During those clocks code_out carries the code MSB first. Any other word has no effect. mi_sync low restarts the bit count.
- R7: key_pending rises when an event is accepted and falls at the read that sends the code.
- R8: A press event that arrives while key_pending is high is discarded. alarm is then set and stays set until the next read, and the read sends the older code.
- R9: sw_state bits [7:0] take sw_ret as sampled at the end of strobe 0. Bits [15:8] take sw_ret as sampled at the end of strobe 1. Samples taken on strobes 2 and 3 leave sw_state unchanged.
- R10: During reset the strobes are zero, key_pending and alarm are low, code_valid is low and sw_state is zero.
- R11: When several keys on one strobe become pressed at the same sample, only the lowest return number is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| strobe | output | 4 | one-hot scan strobe |
| key_ret | input | 8 | key return lines for the active strobe |
| sw_ret | input | 8 | switch return lines for the active strobe |
| mi_sync | input | 1 | serial command framing strobe |
| mi | input | 1 | serial command data, MSB first |
| key_pending | output | 1 | an unread key code is held |
| alarm | output | 1 | a press was lost while a code was unread |
| code_valid | output | 1 | serial key code is being sent |
| code_out | output | 1 | serial key code data, MSB first |
| sw_state | output | 16 | latched switch levels |

## Verification
Returns are sampled on the last clock of each strobe. A press that is stable from one sample onward is therefore accepted at the same strobe's sample one scan (4*DWELL clocks) later, and key_pending is high from the following cycle. sw_state moves the cycle after the end of strobe 0 or 1. The code's first bit is on the output in the cycle after the edge that takes the 8th command bit. The bench model counts edges since reset to place each of these moments. It compares every output at each falling edge, half a clock after the edge that changed them. The directed checks wait whole scans before they sample.

// File: rtl/keyscan_matrix.sv
module keyscan_matrix #(
  parameter int NSTROBE   = 4,
  parameter int NRET      = 8,
  parameter int DWELL     = 4,
  parameter int NSWSTROBE = 2,
  parameter logic [7:0] CMD_READ = 8'hA5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic [NSTROBE-1:0]        strobe,
  input  logic [NRET-1:0]           key_ret,
  input  logic [NRET-1:0]           sw_ret,
  input  logic                      mi_sync,
  input  logic                      mi,
  output logic                      key_pending,
  output logic                      alarm,
  output logic                      code_valid,
  output logic                      code_out,
  output logic [NSWSTROBE*NRET-1:0] sw_state
);
  localparam int SW   = $clog2(NSTROBE);
  localparam int RW   = $clog2(NRET);
  localparam int CW   = SW + RW;
  localparam int NKEY = NSTROBE * NRET;
  localparam int DCW  = $clog2(DWELL);
  localparam int TW   = $clog2(CW + 1);

  logic           run;
  logic [DCW-1:0] dcnt;
  logic [SW-1:0]  sidx;
  logic           samp;

  assign samp   = run && (dcnt == DCW'(DWELL - 1));
  assign strobe = run ? ({{(NSTROBE-1){1'b0}}, 1'b1} << sidx) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run  <= 1'b0;
      dcnt <= '0;
      sidx <= '0;
    end else begin
      run <= 1'b1;
      if (samp) begin
        dcnt <= '0;
        sidx <= (sidx == SW'(NSTROBE - 1)) ? '0 : sidx + 1'b1;
      end else if (run) begin
        dcnt <= dcnt + 1'b1;
      end
    end

  logic [NKEY-1:0] prev, stab;
  logic [NRET-1:0] rise;
  logic            hit;
  logic [RW-1:0]   pick;

  always_comb begin
    for (int r = 0; r < NRET; r++)
      rise[r] = key_ret[r] && prev[int'(sidx)*NRET + r] && !stab[int'(sidx)*NRET + r];
    hit  = 1'b0;
    pick = '0;
    for (int r = NRET - 1; r >= 0; r--)
      if (rise[r]) begin
        hit  = 1'b1;
        pick = RW'(r);
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev <= '0;
      stab <= '0;
    end else if (samp) begin
      for (int r = 0; r < NRET; r++) begin
        prev[int'(sidx)*NRET + r] <= key_ret[r];
        if (key_ret[r] == prev[int'(sidx)*NRET + r])
          stab[int'(sidx)*NRET + r] <= key_ret[r];
      end
    end

  logic [7:0] cmd_sh;
  logic [2:0] bcnt;
  logic [7:0] word;
  logic       rd, press, take;

  assign word  = {cmd_sh[6:0], mi};
  assign rd    = mi_sync && (bcnt == 3'd7) && (word == CMD_READ) && key_pending;
  assign press = samp && hit;
  assign take  = press && (!key_pending || rd);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_sh <= '0;
      bcnt   <= '0;
    end else if (mi_sync) begin
      cmd_sh <= word;
      bcnt   <= bcnt + 1'b1;
    end else begin
      bcnt   <= '0;
    end

  logic [CW-1:0] code, tx_sh;
  logic [TW-1:0] tx_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      key_pending <= 1'b0;
      alarm       <= 1'b0;
      code        <= '0;
      tx_sh       <= '0;
      tx_n        <= '0;
    end else begin
      key_pending <= (key_pending && !rd) || press;
      if (take)
        code <= {sidx, pick};
      if (rd)
        alarm <= 1'b0;
      else if (press && key_pending)
        alarm <= 1'b1;
      if (rd) begin
        tx_sh <= code;
        tx_n  <= TW'(CW);
      end else if (tx_n != '0) begin
        tx_sh <= tx_sh << 1;
        tx_n  <= tx_n - 1'b1;
      end
    end

  assign code_valid = (tx_n != '0);
  assign code_out   = code_valid && tx_sh[CW-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      sw_state <= '0;
    else if (samp && int'(sidx) < NSWSTROBE)
      sw_state[int'(sidx)*NRET +: NRET] <= sw_ret;

endmodule

module keyscan_matrix_chk #(
  parameter int NS  = 4,
  parameter int NSW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NS-1:0]  strobe,
  input logic           key_pending,
  input logic           alarm,
  input logic           code_valid,
  input logic [NSW-1:0] sw_state
);
  logic [NS-1:0] prv;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prv <= '0;
    else        prv <= strobe;

  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(strobe));
  // R1
  strobe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prv != '0 && strobe != prv) |-> strobe == {prv[NS-2:0], prv[NS-1]});
  // R10
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (strobe == '0 && !key_pending && !alarm && sw_state == '0));
  // R8
  alarm_pend_chk: assert property (@(posedge clk) disable iff (!rst_n) alarm |-> key_pending);
  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(key_pending) |-> code_valid);
  // R6
  tx_len_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(code_valid) |-> $past(code_valid, 5));
  // R9
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe[2] || strobe[3]) |=> $stable(sw_state));
endmodule

bind keyscan_matrix keyscan_matrix_chk #(.NS(NSTROBE), .NSW(NSWSTROBE*NRET)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .key_pending(key_pending),
  .alarm(alarm), .code_valid(code_valid), .sw_state(sw_state));

// File: tb/keyscan_matrix_tb.sv
`timescale 1ns/1ps
module keyscan_matrix_tb;
  localparam int DWELL = 4;
  localparam int SCAN  = 4 * DWELL;

  logic clk = 0, rst_n = 0;
  logic [3:0] strobe;
  logic [7:0] key_ret = '0, sw_ret = '0;
  logic mi_sync = 0, mi = 0;
  logic key_pending, alarm, code_valid, code_out;
  logic [15:0] sw_state;

  logic [31:0] keys = '0, swbank = '0;
  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  keyscan_matrix #(.DWELL(DWELL)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .key_ret(key_ret), .sw_ret(sw_ret),
    .mi_sync(mi_sync), .mi(mi), .key_pending(key_pending), .alarm(alarm),
    .code_valid(code_valid), .code_out(code_out), .sw_state(sw_state));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int k = 0, mbits = 0;
  logic [31:0] mprev = '0, mstab = '0;
  logic mpend = 0, malarm = 0;
  logic [4:0] mcode = '0;
  logic [7:0] mword = '0;
  logic [15:0] msw = '0;
  bit txq[$];

  function automatic int cur_idx();
    return (k == 0) ? -1 : ((k - 1) / DWELL) % 4;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      k = 0; mbits = 0; mprev = '0; mstab = '0; mpend = 0; malarm = 0;
      mcode = '0; mword = '0; msw = '0; txq = {};
    end else begin
      int j, s, nc;
      bit rd, hit;
      k++;
      j = k - 1;
      rd = 0; hit = 0; nc = 0;
      if (mi_sync) begin
        mword = {mword[6:0], mi};
        mbits++;
        if (mbits == 8) begin
          mbits = 0;
          rd = (mword == 8'hA5) && mpend;
        end
      end else mbits = 0;
      if (j > 0 && j % DWELL == 0) begin
        s = (j / DWELL - 1) % 4;
        for (int r = 0; r < 8; r++) begin
          if (key_ret[r] == mprev[s*8+r] && key_ret[r] != mstab[s*8+r]) begin
            mstab[s*8+r] = key_ret[r];
            if (key_ret[r] && !hit) begin hit = 1; nc = s*8 + r; end
          end
          mprev[s*8+r] = key_ret[r];
        end
        if (s < 2) msw[s*8 +: 8] = sw_ret;
      end
      if (rd) begin
        txq = {};
        for (int b = 4; b >= 0; b--) txq.push_back(mcode[b]);
      end else if (txq.size() > 0) void'(txq.pop_front());
      if (hit && (!mpend || rd)) mcode = nc[4:0];
      if (rd) malarm = 0;
      else if (hit && mpend) malarm = 1;
      mpend = (mpend && !rd) || hit;
    end
  end

  always @(negedge clk) begin
    int i;
    logic [3:0] es;
    i = cur_idx();
    key_ret <= (i < 0) ? 8'h00 : keys[i*8 +: 8];
    sw_ret  <= (i < 0) ? 8'h00 : swbank[i*8 +: 8];
    es = (i < 0) ? 4'b0 : 4'b1 << i;
    chk(strobe == es, "R1", "strobe", strobe, es);
    chk(key_pending == mpend, "R7", "key_pending", key_pending, mpend);
    chk(alarm == malarm, "R8", "alarm", alarm, malarm);
    chk(code_valid == (txq.size() > 0), "R6", "code_valid", code_valid, txq.size() > 0);
    chk(code_out == ((txq.size() > 0) ? txq[0] : 1'b0), "R6", "code_out", code_out,
        (txq.size() > 0) ? txq[0] : 1'b0);
    chk(sw_state == msw, "R9", "sw_state", sw_state, msw);
  end

  task automatic scans(input int n);
    repeat (n * SCAN) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] w, output logic [4:0] rx, output bit seen);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      mi_sync = 1; mi = w[i];
    end
    @(negedge clk);
    mi_sync = 0; mi = 0;
    rx = '0; seen = 0;
    for (int b = 4; b >= 0; b--) begin
      if (b != 4) @(negedge clk);
      #1;
      rx[b] = code_out;
      if (code_valid) seen = 1;
    end
  endtask

  logic [4:0] rx;
  bit seen;

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R10
    chk(strobe == 0 && !key_pending && !alarm && !code_valid && sw_state == 0, "R10",
        "reset state", {strobe, key_pending, alarm, code_valid}, 0);
    @(negedge clk) rst_n = 1;

    keys[13] = 1; scans(3);
    chk(key_pending == 1, "R7", "pending after press", key_pending, 1);
    send_cmd(8'hA5, rx, seen);
    chk(rx == 5'd13 && seen, "R2", "code of strobe1 ret5", rx, 13);
    chk(key_pending == 0, "R6", "pending after read", key_pending, 0);

    scans(4);
    chk(key_pending == 0, "R3", "held key repeats", key_pending, 0);

    keys[30] = 1; scans(3);
    chk(key_pending == 1, "R5", "second key while first held", key_pending, 1);
    send_cmd(8'hA5, rx, seen);
    chk(rx == 5'd30, "R5", "rollover code", rx, 30);

    keys = '0; scans(3);
    chk(key_pending == 0, "R3", "release gives no event", key_pending, 0);

    keys[13] = 1; scans(3);
    send_cmd(8'hA5, rx, seen);
    chk(rx == 5'd13 && seen, "R3", "re-press gives new event", rx, 13);
    keys = '0; scans(3);

    @(negedge clk) keys[2] = 1;
    repeat (2 * DWELL) @(negedge clk);
    keys[2] = 0; scans(3);
    chk(key_pending == 0, "R4", "single-sample glitch", key_pending, 0);

    keys[7] = 1; scans(3);
    send_cmd(8'h5A, rx, seen);
    chk(!seen && key_pending == 1, "R6", "other word ignored", {seen, key_pending}, 1);
    send_cmd(8'hA5, rx, seen);
    chk(rx == 5'd7, "R6", "code after ignored word", rx, 7);
    keys = '0; scans(3);

    keys[3] = 1; scans(3);
    keys[9] = 1; scans(3);
    chk(alarm == 1, "R8", "alarm on lost press", alarm, 1);
    send_cmd(8'hA5, rx, seen);
    chk(rx == 5'd3, "R8", "older code kept", rx, 3);
    chk(alarm == 0 && key_pending == 0, "R8", "alarm cleared by read", {alarm, key_pending}, 0);
    keys = '0; scans(3);

    keys[17] = 1; keys[20] = 1; scans(3);
    send_cmd(8'hA5, rx, seen);
    chk(rx == 5'd17, "R11", "lowest return wins", rx, 17);
    keys = '0; scans(3);

    swbank = 32'hDEAD_3C81; scans(2);
    chk(sw_state == 16'h3C81, "R9", "switch bank", sw_state, 16'h3C81);
    swbank = 32'h1234_00FF; scans(2);
    chk(sw_state == 16'h00FF, "R9", "switch bank update", sw_state, 16'h00FF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule